// File: doc/BRIEF.md
# Key-Configured Reversible Gate Cascade Cipher

This block enciphers or deciphers a 4-bit word. The word passes through sixteen stages, and each stage is a reversible gate on four lines. An 80-bit main key selects the gate at each stage: it is cut into sixteen 5-bit groups, one per stage. Every gate the key can select is a NOT, a single- or multi-controlled NOT on one target line, and every such gate is its own inverse. So deciphering uses the same key and walks the stages in the opposite order. No separate inverse logic is needed.

The engine is iterative and applies one stage per clock. A one-cycle start request is accepted only while the engine is idle. At that edge the key, the data word and the direction are captured. After the sixteenth stage the result is placed on the output, and a one-cycle done pulse marks it. The result stays on the output until the next operation completes.

Top module: `revgate_cipher`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `data_o` is 0 until the first operation completes.
- R2: Stage i is configured by key bits [5i+4:5i]. Within a group, bits [1:0] give the target line t. Bits [4:2] give a selector s for the controls, drawn from the other three lines. Those lines are ranked o0<o1<o2 by index, and the selector maps as follows: s=0 none, 1 {o0}, 2 {o1}, 3 {o2}, 4 {o0,o1}, 5 {o0,o2}, 6 {o1,o2}, 7 {o0,o1,o2}.
- R3: A stage inverts data bit t exactly when every selected control bit is 1. With no controls it always inverts bit t. All other bits pass unchanged.
- R4: With `decrypt_i`=0 at acceptance, the stages are applied in order 0,1,...,15.
- R5: With `decrypt_i`=1 at acceptance, the stages are applied in order 15,...,1,0. Deciphering the ciphertext under the same key returns the plaintext.
- R6: `done_o` rises on the 16th rising edge after the edge that accepts start, and it is high for exactly one cycle.
- R7: `data_o` changes only on the edge at which `done_o` rises, and it holds its value otherwise.
- R8: A start request while an operation is in progress is ignored. It does not alter the running operation and does not produce an extra completion.
- R9: Key, data and direction are sampled on the accepting edge. Changes to those inputs afterwards have no effect on the result.
- R10: For any fixed key, encryption maps the 16 input values onto 16 distinct output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request a new operation; taken only when idle |
| decrypt_i | input | 1 | 0 = encipher, 1 = decipher; sampled with start |
| key_i | input | 80 | Main key, sixteen 5-bit stage groups |
| data_i | input | 4 | Input word; sampled with start |
| data_o | output | 4 | Result of the last completed operation |
| done_o | output | 1 | One-cycle pulse when a result appears |

## Verification
Three kinds of key drive the cipher, each with all sixteen plaintexts. The all-zero key selects an unconditional NOT on line 0 at every stage and must return each word unchanged. Random keys are compared against an independent gate model in both directions. A key whose gates do not commute shows whether the decipher path really reverses the stage order, since the forward order on ciphertext gives a different word. Mid-operation start pulses and changes to the key and data show whether the engine samples only at acceptance. The permutation check shows whether any stage loses information.

// File: rtl/revgate_pkg.sv
package revgate_pkg;
  localparam int LINES = 4;
  localparam int CFG_W = 5;
  localparam int TGT_W = 2;

  typedef logic [LINES-1:0] word_t;

  typedef struct packed {
    logic [TGT_W-1:0] tgt;
    logic [LINES-1:0] ctl_mask;
  } gate_cfg_t;
endpackage

// File: rtl/revgate_keysel.sv
module revgate_keysel #(
  parameter int STAGES = 16,
  localparam int KEY_W = STAGES * revgate_pkg::CFG_W,
  localparam int IDX_W = $clog2(STAGES)
) (
  input  logic [KEY_W-1:0]               key,
  input  logic [IDX_W-1:0]               idx,
  output logic [revgate_pkg::CFG_W-1:0]  grp
);
  logic [revgate_pkg::CFG_W-1:0] groups [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_split
    assign groups[g] = key[g*revgate_pkg::CFG_W +: revgate_pkg::CFG_W];
  end

  assign grp = groups[idx];
endmodule

// File: rtl/revgate_decode.sv
module revgate_decode
  import revgate_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output gate_cfg_t        gate
);
  logic [2:0] rank_sel;
  logic [1:0] rank;

  always_comb begin
    case (cfg[4:2])
      3'd0:    rank_sel = 3'b000;
      3'd1:    rank_sel = 3'b001;
      3'd2:    rank_sel = 3'b010;
      3'd3:    rank_sel = 3'b100;
      3'd4:    rank_sel = 3'b011;
      3'd5:    rank_sel = 3'b101;
      3'd6:    rank_sel = 3'b110;
      default: rank_sel = 3'b111;
    endcase
  end

  always_comb begin
    gate.tgt      = cfg[1:0];
    gate.ctl_mask = '0;
    rank          = 2'd0;
    for (int j = 0; j < LINES; j++) begin
      if (j[1:0] != cfg[1:0]) begin
        gate.ctl_mask[j] = rank_sel[rank];
        rank = rank + 2'd1;
      end
    end
  end
endmodule

// File: rtl/revgate_stage.sv
module revgate_stage
  import revgate_pkg::*;
(
  input  word_t     din,
  input  gate_cfg_t gate,
  output word_t     dout
);
  logic  fire;
  word_t flip;

  assign fire = ((din & gate.ctl_mask) == gate.ctl_mask);

  always_comb begin
    flip = '0;
    flip[gate.tgt] = fire;
  end

  assign dout = din ^ flip;
endmodule

// File: rtl/revgate_ctrl.sv
module revgate_ctrl #(
  parameter int STAGES = 16,
  localparam int IDX_W = $clog2(STAGES),
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(STAGES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             decrypt,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic             dir,
  output logic [IDX_W-1:0] stage,
  output logic             done
);
  logic             busy_q, busy_d;
  logic             dir_q, dir_d;
  logic [IDX_W-1:0] stage_q, stage_d;
  logic             done_q, done_d;

  assign accept = start && !busy_q;
  assign last   = dir_q ? (stage_q == '0) : (stage_q == IDX_MAX);

  always_comb begin
    busy_d  = busy_q;
    dir_d   = dir_q;
    stage_d = stage_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        dir_d   = decrypt;
        stage_d = decrypt ? IDX_MAX : '0;
      end
    end else if (last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      stage_d = dir_q ? (stage_q - 1'b1) : (stage_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      stage_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      dir_q   <= dir_d;
      stage_q <= stage_d;
      done_q  <= done_d;
    end
  end

  assign busy  = busy_q;
  assign dir   = dir_q;
  assign stage = stage_q;
  assign done  = done_q;
endmodule

// File: rtl/revgate_cipher.sv
module revgate_cipher
  import revgate_pkg::*;
#(
  parameter int STAGES = 16,
  localparam int KEY_W = STAGES * CFG_W,
  localparam int IDX_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decrypt_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [LINES-1:0] data_i,
  output logic [LINES-1:0] data_o,
  output logic             done_o
);
  logic             accept, busy_q, last, dir_q, done_q;
  logic [IDX_W-1:0] stage_q;
  logic [KEY_W-1:0] key_q;
  word_t            work_q, work_d, step_out, out_q;
  logic [CFG_W-1:0] grp;
  gate_cfg_t        gate;
  logic             work_en, out_en;

  revgate_ctrl #(.STAGES(STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start_i), .decrypt(decrypt_i),
    .accept(accept), .busy(busy_q), .last(last), .dir(dir_q),
    .stage(stage_q), .done(done_q)
  );

  revgate_keysel #(.STAGES(STAGES)) keysel_i (
    .key(key_q), .idx(stage_q), .grp(grp)
  );

  revgate_decode decode_i (.cfg(grp), .gate(gate));

  revgate_stage stage_i (.din(work_q), .gate(gate), .dout(step_out));

  assign work_en = accept || busy_q;
  assign work_d  = accept ? data_i : step_out;
  assign out_en  = busy_q && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      work_q <= '0;
      out_q  <= '0;
    end else begin
      if (accept)  key_q  <= key_i;
      if (work_en) work_q <= work_d;
      if (out_en)  out_q  <= step_out;
    end
  end

  assign data_o = out_q;
  assign done_o = done_q;
endmodule

// File: rtl/revgate_cipher_chk.sv
module revgate_cipher_chk #(
  parameter int STAGES = 16,
  localparam int IDX_W = $clog2(STAGES),
  localparam int CNT_W = $clog2(STAGES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic [3:0]       data_o,
  input logic             busy,
  input logic             dir,
  input logic [IDX_W-1:0] stage
);
  logic [CNT_W-1:0] run_cnt;
  logic             at_end;

  assign at_end = dir ? (stage == '0) : (stage == IDX_W'(STAGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (start_i && !busy)  run_cnt <= '0;
    else if (busy)              run_cnt <= run_cnt + 1'b1;
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == CNT_W'(STAGES)));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(data_o));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |=> (busy && $stable(dir)));

  p_fwd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir && !at_end) |=> (stage == $past(stage) + 1'b1));

  p_rev_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir && !at_end) |=> (stage == $past(stage) - 1'b1));
endmodule

bind revgate_cipher revgate_cipher_chk #(.STAGES(STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .data_o(data_o), .busy(busy_q), .dir(dir_q), .stage(stage_q)
);

// File: tb/revgate_cipher_tb_top.sv
module revgate_cipher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        decrypt_i = 1'b0;
  logic [79:0] key_i = '0;
  logic [3:0]  data_i = '0;
  logic [3:0]  data_o;
  logic        done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  revgate_cipher dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
    .key_i(key_i), .data_i(data_i), .data_o(data_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  function automatic void check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endfunction

  // Model of one stage, built from R2/R3.
  function automatic logic [3:0] gate_model(logic [3:0] x, logic [4:0] g);
    int t = g[1:0];
    int s = g[4:2];
    logic [2:0] use_rank;
    logic ok = 1'b1;
    case (s)
      0: use_rank = 3'b000; 1: use_rank = 3'b001; 2: use_rank = 3'b010;
      3: use_rank = 3'b100; 4: use_rank = 3'b011; 5: use_rank = 3'b101;
      6: use_rank = 3'b110; default: use_rank = 3'b111;
    endcase
    for (int k = 0; k < 3; k++) begin
      int line = (k < t) ? k : k + 1;
      if (use_rank[k] && !x[line]) ok = 1'b0;
    end
    if (ok) x[t] = ~x[t];
    return x;
  endfunction

  function automatic logic [3:0] cipher_model(logic [79:0] k, logic [3:0] x, bit dec);
    for (int i = 0; i < 16; i++) begin
      int st = dec ? 15 - i : i;
      x = gate_model(x, k[st*5 +: 5]);
    end
    return x;
  endfunction

  function automatic logic [79:0] rand_key();
    return {$urandom(), $urandom(), 16'($urandom())};
  endfunction

  // One operation; lat counts edges after the accepting edge up to done.
  task automatic run_op(input bit dec, input logic [79:0] k, input logic [3:0] d,
                        output logic [3:0] res, output int lat);
    @(negedge clk);
    start_i = 1'b1; decrypt_i = dec; key_i = k; data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    res = data_o;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done_o, 0);
    check("R1 data in reset", data_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done after reset", done_o, 0);
    check("R1 data after reset", data_o, 0);
  endtask

  task automatic t_zero_key();
    logic [3:0] r; int lat;
    for (int p = 0; p < 16; p++) begin
      run_op(1'b0, '0, 4'(p), r, lat);
      check("R3 zero key identity", r, p);
    end
  endtask

  task automatic t_random_keys();
    logic [3:0] c, r; int lat;
    for (int n = 0; n < 6; n++) begin
      logic [79:0] k = rand_key();
      logic [15:0] seen = '0;
      for (int p = 0; p < 16; p++) begin
        run_op(1'b0, k, 4'(p), c, lat);
        check("R2 R4 encrypt vs model", c, cipher_model(k, 4'(p), 1'b0));
        check("R6 latency", lat, 16);
        seen[c] = 1'b1;
        run_op(1'b1, k, c, r, lat);
        check("R5 decrypt returns plaintext", r, p);
      end
      check("R10 permutation", seen, 16'hffff);
    end
  endtask

  task automatic t_order();
    // stage 0: CNOT target 1 ctrl line 0 ; stage 1: NOT line 0 ; rest NOT line 3 (cancel in pairs)
    logic [79:0] k = '0;
    logic [3:0] c, r; int lat;
    for (int i = 2; i < 16; i++) k[i*5 +: 5] = 5'b00011;
    k[4:0] = 5'b00101;
    k[9:5] = 5'b00000;
    run_op(1'b0, k, 4'h0, c, lat);
    check("R4 forward order", c, 4'h1);
    run_op(1'b1, k, 4'h0, r, lat);
    check("R5 reverse order", r, 4'h3);
  endtask

  task automatic t_done_pulse_hold();
    logic [3:0] r, held; int lat;
    logic [79:0] k = rand_key();
    run_op(1'b0, k, 4'h9, r, lat);
    held = r;
    @(negedge clk);
    check("R6 done one cycle", done_o, 0);
    key_i = ~key_i; data_i = ~data_i; decrypt_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 output held", data_o, held);
  endtask

  task automatic t_busy_ignore();
    logic [79:0] k = rand_key();
    logic [3:0] exp = cipher_model(k, 4'h6, 1'b0);
    int dones = 0;
    @(negedge clk);
    start_i = 1'b1; decrypt_i = 1'b0; key_i = k; data_i = 4'h6;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1; decrypt_i = 1'b1; key_i = ~k; data_i = 4'hb;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_o) begin
        dones++;
        if (dones == 1) check("R8 result unaffected", data_o, exp);
      end
      @(negedge clk);
    end
    check("R8 single completion", dones, 1);
  endtask

  task automatic t_input_change();
    logic [79:0] k = rand_key();
    logic [3:0] exp = cipher_model(k, 4'h5, 1'b1);
    int lat = 0;
    @(negedge clk);
    start_i = 1'b1; decrypt_i = 1'b1; key_i = k; data_i = 4'h5;
    @(negedge clk);
    start_i = 1'b0; key_i = rand_key(); data_i = 4'ha; decrypt_i = 1'b0;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R9 sampled inputs", data_o, exp);
  endtask

  initial begin
    t_reset();
    t_zero_key();
    t_random_keys();
    t_order();
    t_done_pulse_hold();
    t_busy_ignore();
    t_input_change();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule